// File: doc/BRIEF.md
# Oversampled Serial Receiver with Delivery Gate

This block recovers asynchronous serial frames from a single input line. Each frame has one low start bit, eight data bits with the least significant bit first, and one stop bit. An external sample tick marks sixteen sample slots per bit period. The receiver passes the line through a two-stage synchronizer and watches for a high-to-low transition. When it sees one, it restarts its sub-bit counter on that tick. It decides each bit by a two-out-of-three vote over three slots in the middle of the bit. A start bit that does not vote low is treated as noise, and the receiver goes back to waiting for a new edge.

After the stop bit is voted, a gate decides whether the frame is kept. The frame is written to the output registers only when the receive-complete flag is clear and the stop bit passes the address filter. The filter is open when the mode bit is 0, or when the stop bit is 1. A frame that fails the gate is discarded and leaves no trace. The flag stays set until the consumer pulses the clear input. Baud generation, transmission and parity are outside this block.

Top module: `ovs_rx_gate`

## Requirements
- R1: While reset is high, and on the first clock after it, rx_full, rx_data and rx_stop are all 0.
- R2: The line idles at 1. Reception starts on the first sample tick whose synchronized line is 0 while the value at the previous tick was 1. That tick is sub-bit slot 0 of the start bit.
- R3: Each bit takes the value that at least two of the slot 7, 8 and 9 samples agree on, so one sample flipped among the three does not change the bit.
- R4: If the start bit votes 1, the frame is abandoned and no output changes. The receiver then accepts the next real start edge.
- R5: Data bits arrive least significant first: the first data bit after the start bit lands in rx_data bit 0.
- R6: A frame is accepted when rx_full is 0 and either mp_mode is 0 or the stop bit voted 1. On acceptance, rx_data takes the eight data bits, rx_stop takes the stop bit, and rx_full goes to 1. All three change on the second clock edge after the sample tick of the stop bit's slot 9.
- R7: A frame that completes while rx_full is 1 is discarded, and rx_data and rx_stop keep their values.
- R8: With mp_mode at 1, a frame whose stop bit votes 0 is discarded. With mp_mode at 0, such a frame is delivered with rx_stop at 0.
- R9: rx_full stays 1 until rx_clr is pulsed, and clears on the edge after the pulse. A clear in the same cycle as an acceptance is overridden, so rx_full stays 1.
- R10: Right after the stop bit's slot 9 the receiver is idle again. A start edge on the very next tick begins a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_tick | input | 1 | One-cycle pulse, sixteen per bit period |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| mp_mode | input | 1 | 1 selects the stop-bit address filter |
| rx_clr | input | 1 | Pulse that clears rx_full |
| rx_data | output | 8 | Last accepted data byte |
| rx_stop | output | 1 | Stop bit of the last accepted frame |
| rx_full | output | 1 | Receive-complete flag |

## Verification
A line change reaches the bit engine two clocks later through the synchronizer. In the bench, a level driven for one tick period is therefore sampled by the following tick. A delivered frame shows on the outputs two clock edges after the tick of the stop bit's slot 9: one edge registers the finished frame, and the next edge updates the gated output registers. A clear takes effect on the edge that samples it. The bench runs a behavioural model that counts ticks from the start edge. It updates that model on each rising edge in the same order and compares all three outputs at every falling edge. At the end of each scenario it also checks fixed expected values.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  typedef enum logic {RX_IDLE, RX_BUSY} rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/rxg_sync.sv
module rxg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxg_bitengine.sv
module rxg_bitengine
  import rxg_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              line_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_o
);
  localparam int SUB_W  = $clog2(OVS);
  localparam int MID    = OVS / 2;
  localparam int S_A    = MID - 1;
  localparam int S_B    = MID;
  localparam int S_C    = MID + 1;
  localparam int NBITS  = DATA_W + 2;
  localparam int BIT_W  = $clog2(NBITS + 1);
  localparam int LAST   = NBITS - 1;

  rx_state_t         st;
  logic [SUB_W-1:0]  sub;
  logic [SUB_W-1:0]  sub_nxt;
  logic [BIT_W-1:0]  bitn;
  logic              prev;
  logic              va, vb;
  logic              vote;
  logic [DATA_W-1:0] shreg;

  assign sub_nxt = sub + SUB_W'(1);
  assign vote    = maj3(va, vb, line_i);

  always_ff @(posedge clk) begin
    done_o <= 1'b0;
    if (rst) begin
      st     <= RX_IDLE;
      sub    <= '0;
      bitn   <= '0;
      prev   <= 1'b1;
      va     <= 1'b1;
      vb     <= 1'b1;
      shreg  <= '0;
      data_o <= '0;
      stop_o <= 1'b0;
    end else if (tick_i) begin
      prev <= line_i;
      if (st == RX_IDLE) begin
        if (prev && !line_i) begin
          st   <= RX_BUSY;
          sub  <= '0;
          bitn <= '0;
        end
      end else begin
        sub <= sub_nxt;
        if (sub_nxt == '0) bitn <= bitn + BIT_W'(1);
        if (sub_nxt == SUB_W'(S_A)) va <= line_i;
        if (sub_nxt == SUB_W'(S_B)) vb <= line_i;
        if (sub_nxt == SUB_W'(S_C)) begin
          if (bitn == '0) begin
            if (vote) st <= RX_IDLE;
          end else if (bitn == BIT_W'(LAST)) begin
            st     <= RX_IDLE;
            done_o <= 1'b1;
            stop_o <= vote;
            data_o <= shreg;
          end else begin
            shreg <= {vote, shreg[DATA_W-1:1]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/rxg_gate.sv
module rxg_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  input  logic              mode_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_q,
  output logic              stop_q,
  output logic              full_q
);
  logic accept;

  assign accept = done_i && !full_q && (!mode_i || stop_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      stop_q <= 1'b0;
      full_q <= 1'b0;
    end else if (accept) begin
      data_q <= data_i;
      stop_q <= stop_i;
      full_q <= 1'b1;
    end else if (clr_i) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ovs_rx_gate.sv
module ovs_rx_gate #(
  parameter int OVS       = 16,
  parameter int DATA_W    = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_tick,
  input  logic              rx_in,
  input  logic              mp_mode,
  input  logic              rx_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_stop,
  output logic              rx_full
);
  logic              line_s;
  logic              frm_done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_stop;

  rxg_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_in),
    .q   (line_s)
  );

  rxg_bitengine #(.OVS(OVS), .DATA_W(DATA_W)) u_eng (
    .clk    (clk),
    .rst    (rst),
    .tick_i (samp_tick),
    .line_i (line_s),
    .done_o (frm_done),
    .data_o (frm_data),
    .stop_o (frm_stop)
  );

  rxg_gate #(.DATA_W(DATA_W)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .done_i (frm_done),
    .data_i (frm_data),
    .stop_i (frm_stop),
    .mode_i (mp_mode),
    .clr_i  (rx_clr),
    .data_q (rx_data),
    .stop_q (rx_stop),
    .full_q (rx_full)
  );
endmodule

// File: rtl/rxg_chk.sv
module rxg_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              mode,
  input logic              flag,
  input logic [DATA_W-1:0] data,
  input logic              stop,
  input logic              done,
  input logic              dstop
);
  // R6
  flag_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(done));

  // R6
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !flag && (!mode || dstop)) |=> (flag && stop == $past(dstop)));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (done && flag) |=> ($stable(data) && $stable(stop)));

  // R8
  mp_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !flag && mode && !dstop) |=> (!flag && $stable(data)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr && !done) |=> flag);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !done) |=> !flag);
endmodule

bind ovs_rx_gate rxg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .clr   (rx_clr),
  .mode  (mp_mode),
  .flag  (rx_full),
  .data  (rx_data),
  .stop  (rx_stop),
  .done  (frm_done),
  .dstop (frm_stop)
);

// File: tb/sim_ovs_rx_gate.sv
`timescale 1ns/1ps
module sim_ovs_rx_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic       mode = 1'b0;
  logic       clr;
  logic [7:0] rx_data;
  logic       rx_stop;
  logic       rx_full;

  logic man_clr = 1'b0;
  logic auto_clr = 1'b0;
  logic clr_on_done = 1'b0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ovs_rx_gate u0 (
    .clk       (clk),
    .rst       (rst),
    .samp_tick (tick),
    .rx_in     (rx),
    .mp_mode   (mode),
    .rx_clr    (clr),
    .rx_data   (rx_data),
    .rx_stop   (rx_stop),
    .rx_full   (rx_full)
  );

  // behavioural reference: counts ticks since the start edge
  logic       m_s1, m_s2, m_prev, m_busy, m_done, m_fstop;
  logic       m_a, m_b;
  logic [7:0] m_acc, m_fdata, m_data;
  logic       m_stop, m_flag;
  int         m_phase;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_busy = 0; m_done = 0;
      m_fstop = 0; m_a = 1; m_b = 1; m_acc = 0; m_fdata = 0;
      m_data = 0; m_stop = 0; m_flag = 0; m_phase = 0;
    end else begin
      if (m_done && !m_flag && (!mode || m_fstop)) begin
        m_data = m_fdata; m_stop = m_fstop; m_flag = 1;
      end else if (clr) begin
        m_flag = 0;
      end
      m_done = 0;
      if (tick) begin
        if (!m_busy) begin
          if (m_prev && !m_s2) begin m_busy = 1; m_phase = 0; end
        end else begin
          int k, r;
          logic v;
          m_phase++;
          k = m_phase / 16;
          r = m_phase % 16;
          if (r == 7) m_a = m_s2;
          if (r == 8) m_b = m_s2;
          if (r == 9) begin
            v = (m_a + m_b + m_s2) >= 2;
            if (k == 0) begin
              if (v) m_busy = 0;
            end else if (k == 9) begin
              m_done = 1; m_fstop = v; m_fdata = m_acc; m_busy = 0;
            end else begin
              m_acc[k-1] = v;
            end
          end
        end
        m_prev = m_s2;
      end
      m_s2 = m_s1;
      m_s1 = rx;
    end
  end

  always @(negedge clk) begin
    clr <= man_clr | (auto_clr & rx_full) | (clr_on_done & m_done);
  end

  initial clr = 1'b0;

  // per-clock comparison against the model (R6, R7, R9)
  always @(negedge clk) begin
    if (!rst) begin
      tests++;
      if (rx_full !== m_flag || rx_data !== m_data || rx_stop !== m_stop) begin
        fails++;
        $display("FAIL R6 model t=%0t act full=%b data=%h stop=%b exp full=%b data=%h stop=%b",
                 $time, rx_full, rx_data, rx_stop, m_flag, m_data, m_stop);
      end
    end
  end

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] outs();
    return {rx_full, rx_stop, rx_data};
  endfunction

  task automatic tick_period(input logic v);
    @(negedge clk); rx = v; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input int glitch);
    for (int p = 0; p < 16; p++) tick_period((p == glitch) ? !v : v);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic sb, input int glitch, input int stop_len);
    send_bit(1'b0, glitch);
    for (int i = 0; i < 8; i++) send_bit(d[i], glitch);
    for (int p = 0; p < stop_len; p++) tick_period(sb);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick_period(1'b1);
  endtask

  task automatic pulse_clr();
    @(negedge clk); man_clr = 1'b1;
    @(negedge clk); man_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values
    check("R1 reset", outs(), 10'h000);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", outs(), 10'h000);
    idle(4);

    // R2, R5, R6: plain frame
    send_frame(8'hA5, 1'b1, -1, 16); idle(3);
    check("R2 R5 R6 deliver A5", outs(), {2'b11, 8'hA5});

    // R7: flag still set, frame dropped
    send_frame(8'h3C, 1'b1, -1, 16); idle(3);
    check("R7 drop while full", outs(), {2'b11, 8'hA5});

    // R9: clear
    pulse_clr();
    check("R9 cleared", outs(), {2'b01, 8'hA5});

    // R3: single sample flipped at slot 8 then slot 7
    send_frame(8'h0F, 1'b1, 8, 16); idle(3);
    check("R3 vote slot8 glitch", outs(), {2'b11, 8'h0F});
    pulse_clr();
    send_frame(8'hF0, 1'b1, 7, 16); idle(3);
    check("R3 vote slot7 glitch", outs(), {2'b11, 8'hF0});
    pulse_clr();

    // R4: short low pulse is a false start
    for (int p = 0; p < 16; p++) tick_period(p < 7 ? 1'b0 : 1'b1);
    idle(180);
    check("R4 false start ignored", outs(), {2'b01, 8'hF0});
    send_frame(8'h81, 1'b1, -1, 16); idle(3);
    check("R4 R5 recovery 81", outs(), {2'b11, 8'h81});
    pulse_clr();

    // R8: address filter
    mode = 1'b1;
    send_frame(8'h55, 1'b0, -1, 16); idle(3);
    check("R8 mode1 stop0 dropped", outs(), {2'b01, 8'h81});
    send_frame(8'h66, 1'b1, -1, 16); idle(3);
    check("R8 mode1 stop1 kept", outs(), {2'b11, 8'h66});
    pulse_clr();
    mode = 1'b0;
    send_frame(8'h99, 1'b0, -1, 16); idle(3);
    check("R8 mode0 stop0 kept", outs(), {2'b10, 8'h99});
    pulse_clr();

    // R9: clear coincident with delivery loses
    clr_on_done = 1'b1;
    send_frame(8'h12, 1'b1, -1, 16); idle(3);
    check("R9 clear overridden", outs(), {2'b11, 8'h12});
    clr_on_done = 1'b0;
    pulse_clr();

    // R10: back-to-back frames with a stop bit cut right after slot 9
    auto_clr = 1'b1;
    send_frame(8'h34, 1'b1, -1, 10);
    send_frame(8'h56, 1'b1, -1, 16); idle(3);
    check("R10 back-to-back data", {2'b00, rx_data}, {2'b00, 8'h56});
    auto_clr = 1'b0;
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule